// File: doc/BRIEF.md
# Reset-Time Protection Configuration Loader

This block runs once after every reset and settles whether flash protection is in force. It fetches a 32-bit confirmation word and a 16-bit sector lock mask from a configuration store through a simple read port. The store answers each read with a data word and a two-bit ECC verdict. When the first location of an item comes back uncorrectable, the block reads that item's redundant location instead. The block then publishes its verdict once, all at the same time, and raises a done flag.

The policy fails secure. A confirmation word that was read cleanly but does not match the expected key leaves protection off. A confirmation word that cannot be read from either location turns protection on and raises both a double-bit-error flag and a protection-fault flag. A sector mask that cannot be read from either location locks every sector. The flash array, the ECC logic and any password unlock path are outside this block.

Top module: `pcfg_loader`

## Requirements
- R1: After reset is released, the first request goes to the code page at byte offset 0 (default address 0x200). The code item is resolved before the mask item, which starts at byte offset 0 of the mask page (default address 0x100).
- R2: An ECC verdict of 00 (clean) or 01 (single-bit corrected) makes the data usable. A verdict of 10 or 11 makes it unusable. The redundant location, at byte offset 8 of the same page, is requested only when the first location's verdict is unusable.
- R3: `prot_on` goes to 1 when the resolved code word equals 0x8AFE15C3. It stays 0 when a usable code word holds any other value.
- R4: When both code locations are unusable, `prot_on`, `dbe_flag` and `prot_fault` all go to 1.
- R5: `sect_lock` takes bits 15:0 of the resolved mask word. Bits 31:16 are ignored.
- R6: When both mask locations are unusable, `sect_lock` becomes all ones and `dbe_flag` goes to 1. `prot_fault` is not set by a mask failure.
- R7: `rd_req` stays high with a stable `rd_addr` until `rd_vld` is sampled high. A response is consumed only in a cycle where both `rd_req` and `rd_vld` are high.
- R8: Until `load_done` is high, every result output holds its reset value: protection off, mask zero, both flags clear.
- R9: `load_done` rises once all reads are resolved. From then until the next reset, all outputs stay stable and no further request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. It is released synchronously inside the block. |
| rd_req | output | 1 | Read request, held high until it is accepted |
| rd_addr | output | ADDR_W (12) | Byte address of the requested word |
| rd_vld | input | 1 | The response is present on this cycle |
| rd_data | input | 32 | Read data |
| rd_ecc | input | 2 | ECC verdict: 00 clean, 01 corrected, 10 or 11 uncorrectable |
| prot_on | output | 1 | Protection is installed |
| sect_lock | output | SECT_W (16) | Latched per-sector lock mask |
| dbe_flag | output | 1 | Both locations of an item were uncorrectable |
| prot_fault | output | 1 | Both confirmation-code locations were uncorrectable |
| load_done | output | 1 | The loader has finished. Outputs are final. |

## Verification
A wrong sequencer state shows up at the read port first. A request to a redundant location after a usable first read, or a request missing after an unusable one, changes the address order that the bench logs. That difference is visible within one handshake of the fault. A wrong staging register stays hidden until the single publish cycle. After that, `prot_on`, `sect_lock` and the flags differ from the bench's model on the first sample after `load_done` rises. A broken hold shows as a drift or a new request within a few cycles after done.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

  // ECC verdict codes carried on the read port
  localparam logic [1:0] ECC_CLEAN = 2'b00;
  localparam logic [1:0] ECC_FIXED = 2'b01;

  typedef enum logic [2:0] {
    ST_LAUNCH,
    ST_CODE_PRI,
    ST_CODE_CPY,
    ST_MASK_PRI,
    ST_MASK_CPY,
    ST_PUBLISH,
    ST_HOLD
  } seq_st_e;

  typedef enum logic {
    ITEM_CODE,
    ITEM_MASK
  } item_e;

  // Upper verdict bit marks data that cannot be trusted (10 or 11)
  function automatic logic ecc_unusable(input logic [1:0] verdict);
    return verdict[1];
  endfunction

endpackage

// File: rtl/pcfg_rst_sync.sv
module pcfg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sh_d = 1'b1;
    end else begin : g_many
      always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];

endmodule

// File: rtl/pcfg_fetch_ctl.sv
module pcfg_fetch_ctl
  import pcfg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned CODE_BASE = 'h200,
  parameter int unsigned MASK_BASE = 'h100,
  parameter int unsigned COPY_OFS  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_vld,
  input  logic [1:0]        rd_ecc,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              cap_en,
  output item_e             cap_item,
  output logic              cap_bad,
  output logic              fin
);

  localparam logic [ADDR_W-1:0] CODE_PRI_A = ADDR_W'(CODE_BASE);
  localparam logic [ADDR_W-1:0] CODE_CPY_A = ADDR_W'(CODE_BASE + COPY_OFS);
  localparam logic [ADDR_W-1:0] MASK_PRI_A = ADDR_W'(MASK_BASE);
  localparam logic [ADDR_W-1:0] MASK_CPY_A = ADDR_W'(MASK_BASE + COPY_OFS);

  seq_st_e st_q, st_d;
  logic    take;
  logic    bad;

  // Request and address follow the state alone, so they stay stable until accepted
  always_comb begin
    rd_req  = 1'b0;
    rd_addr = '0;
    case (st_q)
      ST_CODE_PRI: begin rd_req = 1'b1; rd_addr = CODE_PRI_A; end
      ST_CODE_CPY: begin rd_req = 1'b1; rd_addr = CODE_CPY_A; end
      ST_MASK_PRI: begin rd_req = 1'b1; rd_addr = MASK_PRI_A; end
      ST_MASK_CPY: begin rd_req = 1'b1; rd_addr = MASK_CPY_A; end
      default:     begin rd_req = 1'b0; rd_addr = '0;         end
    endcase
  end

  assign take = rd_req & rd_vld;
  assign bad  = ecc_unusable(rd_ecc);

  // Next-state and capture strobes
  always_comb begin
    st_d     = st_q;
    cap_en   = 1'b0;
    cap_item = ITEM_CODE;
    cap_bad  = 1'b0;
    fin      = 1'b0;
    case (st_q)
      ST_LAUNCH: st_d = ST_CODE_PRI;
      ST_CODE_PRI: begin
        if (take) begin
          if (bad) begin
            st_d = ST_CODE_CPY;
          end else begin
            cap_en = 1'b1;
            st_d   = ST_MASK_PRI;
          end
        end
      end
      ST_CODE_CPY: begin
        if (take) begin
          cap_en  = 1'b1;
          cap_bad = bad;
          st_d    = ST_MASK_PRI;
        end
      end
      ST_MASK_PRI: begin
        cap_item = ITEM_MASK;
        if (take) begin
          if (bad) begin
            st_d = ST_MASK_CPY;
          end else begin
            cap_en = 1'b1;
            st_d   = ST_PUBLISH;
          end
        end
      end
      ST_MASK_CPY: begin
        cap_item = ITEM_MASK;
        if (take) begin
          cap_en  = 1'b1;
          cap_bad = bad;
          st_d    = ST_PUBLISH;
        end
      end
      ST_PUBLISH: begin
        fin  = 1'b1;
        st_d = ST_HOLD;
      end
      ST_HOLD:  st_d = ST_HOLD;
      default:  st_d = ST_LAUNCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_LAUNCH;
    else        st_q <= st_d;
  end

endmodule

// File: rtl/pcfg_result.sv
module pcfg_result
  import pcfg_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SECT_W  = 16,
  parameter logic [31:0] CONFIRM = 32'h8AFE15C3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  item_e             cap_item,
  input  logic              cap_bad,
  input  logic [DATA_W-1:0] cap_data,
  input  logic              fin,
  output logic              prot_on,
  output logic [SECT_W-1:0] sect_lock,
  output logic              dbe_flag,
  output logic              prot_fault,
  output logic              load_done
);

  // Staging: holds each item's verdict until publication
  logic              code_ld, mask_ld;
  logic              code_hit_q, code_hit_d;
  logic              code_bad_q, code_bad_d;
  logic [SECT_W-1:0] mask_q, mask_d;
  logic              mask_bad_q, mask_bad_d;

  // Published outputs
  logic              on_q, on_d;
  logic [SECT_W-1:0] lock_q, lock_d;
  logic              dbe_q, dbe_d;
  logic              flt_q, flt_d;
  logic              done_q, done_d;

  assign code_ld = cap_en & (cap_item == ITEM_CODE);
  assign mask_ld = cap_en & (cap_item == ITEM_MASK);

  always_comb begin
    code_hit_d = (cap_data[31:0] == CONFIRM);
    code_bad_d = cap_bad;
    mask_bad_d = cap_bad;
    mask_d     = cap_bad ? {SECT_W{1'b1}} : cap_data[SECT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_hit_q <= 1'b0;
      code_bad_q <= 1'b0;
    end else if (code_ld) begin
      code_hit_q <= code_hit_d;
      code_bad_q <= code_bad_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q     <= '0;
      mask_bad_q <= 1'b0;
    end else if (mask_ld) begin
      mask_q     <= mask_d;
      mask_bad_q <= mask_bad_d;
    end
  end

  // Fail secure: an unreadable code counts as installed
  always_comb begin
    on_d   = code_bad_q | code_hit_q;
    lock_d = mask_q;
    dbe_d  = code_bad_q | mask_bad_q;
    flt_d  = code_bad_q;
    done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q   <= 1'b0;
      lock_q <= '0;
      dbe_q  <= 1'b0;
      flt_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (fin) begin
      on_q   <= on_d;
      lock_q <= lock_d;
      dbe_q  <= dbe_d;
      flt_q  <= flt_d;
      done_q <= done_d;
    end
  end

  assign prot_on    = on_q;
  assign sect_lock  = lock_q;
  assign dbe_flag   = dbe_q;
  assign prot_fault = flt_q;
  assign load_done  = done_q;

endmodule

// File: rtl/pcfg_loader.sv
module pcfg_loader
  import pcfg_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned SECT_W     = 16,
  parameter int unsigned CODE_BASE  = 'h200,
  parameter int unsigned MASK_BASE  = 'h100,
  parameter int unsigned COPY_OFS   = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [31:0] CONFIRM    = 32'h8AFE15C3
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_vld,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [1:0]        rd_ecc,
  output logic              prot_on,
  output logic [SECT_W-1:0] sect_lock,
  output logic              dbe_flag,
  output logic              prot_fault,
  output logic              load_done
);

  logic  rst_int_n;
  logic  cap_en;
  item_e cap_item;
  logic  cap_bad;
  logic  fin;

  pcfg_rst_sync #(.STAGES(SYNC_STAGES)) rst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  pcfg_fetch_ctl #(
    .ADDR_W    (ADDR_W),
    .CODE_BASE (CODE_BASE),
    .MASK_BASE (MASK_BASE),
    .COPY_OFS  (COPY_OFS)
  ) fetch_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .rd_vld   (rd_vld),
    .rd_ecc   (rd_ecc),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .cap_en   (cap_en),
    .cap_item (cap_item),
    .cap_bad  (cap_bad),
    .fin      (fin)
  );

  pcfg_result #(
    .DATA_W  (DATA_W),
    .SECT_W  (SECT_W),
    .CONFIRM (CONFIRM)
  ) res_i (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cap_en     (cap_en),
    .cap_item   (cap_item),
    .cap_bad    (cap_bad),
    .cap_data   (rd_data),
    .fin        (fin),
    .prot_on    (prot_on),
    .sect_lock  (sect_lock),
    .dbe_flag   (dbe_flag),
    .prot_fault (prot_fault),
    .load_done  (load_done)
  );

endmodule

// File: rtl/pcfg_loader_chk.sv
module pcfg_loader_chk #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned SECT_W    = 16,
  parameter int unsigned CODE_BASE = 'h200,
  parameter int unsigned MASK_BASE = 'h100,
  parameter int unsigned COPY_OFS  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_vld,
  input logic              prot_on,
  input logic [SECT_W-1:0] sect_lock,
  input logic              dbe_flag,
  input logic              prot_fault,
  input logic              load_done
);

  localparam logic [ADDR_W-1:0] A0 = ADDR_W'(CODE_BASE);
  localparam logic [ADDR_W-1:0] A1 = ADDR_W'(CODE_BASE + COPY_OFS);
  localparam logic [ADDR_W-1:0] A2 = ADDR_W'(MASK_BASE);
  localparam logic [ADDR_W-1:0] A3 = ADDR_W'(MASK_BASE + COPY_OFS);

  a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_vld |=> rd_req && $stable(rd_addr));

  a_r1_addr_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (rd_addr == A0) || (rd_addr == A1) || (rd_addr == A2) || (rd_addr == A3));

  a_r8_quiet_before_done: assert property (@(posedge clk) disable iff (!rst_n)
    !load_done |-> !prot_on && (sect_lock == '0) && !dbe_flag && !prot_fault);

  a_r9_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> load_done && $stable(prot_on) && $stable(sect_lock)
                  && $stable(dbe_flag) && $stable(prot_fault));

  a_r9_no_req_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> !rd_req);

  a_r4_fault_secure: assert property (@(posedge clk) disable iff (!rst_n)
    prot_fault |-> dbe_flag && prot_on);

endmodule

bind pcfg_loader pcfg_loader_chk #(
  .ADDR_W    (ADDR_W),
  .SECT_W    (SECT_W),
  .CODE_BASE (CODE_BASE),
  .MASK_BASE (MASK_BASE),
  .COPY_OFS  (COPY_OFS)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_req     (rd_req),
  .rd_addr    (rd_addr),
  .rd_vld     (rd_vld),
  .prot_on    (prot_on),
  .sect_lock  (sect_lock),
  .dbe_flag   (dbe_flag),
  .prot_fault (prot_fault),
  .load_done  (load_done)
);

// File: tb/pcfg_loader_tb_top.sv
`timescale 1ns/1ps
module pcfg_loader_tb_top;

  localparam int AW = 12;
  localparam logic [AW-1:0] CP = 12'h200;
  localparam logic [AW-1:0] CC = 12'h208;
  localparam logic [AW-1:0] MP = 12'h100;
  localparam logic [AW-1:0] MC = 12'h108;
  localparam logic [31:0]   KEY = 32'h8AFE15C3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          rd_req;
  logic [AW-1:0] rd_addr;
  logic          rd_vld;
  logic [31:0]   rd_data;
  logic [1:0]    rd_ecc;
  logic          prot_on;
  logic [15:0]   sect_lock;
  logic          dbe_flag;
  logic          prot_fault;
  logic          load_done;

  pcfg_loader dut_i (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_vld(rd_vld), .rd_data(rd_data), .rd_ecc(rd_ecc),
    .prot_on(prot_on), .sect_lock(sect_lock), .dbe_flag(dbe_flag),
    .prot_fault(prot_fault), .load_done(load_done)
  );

  int checks = 0;
  int errors = 0;

  // Scenario contents of the configuration store
  logic [1:0]  cs_p, cs_c, ms_p, ms_c;
  logic [31:0] cv_p, cv_c, mv_p, mv_c;

  logic [AW-1:0] log_a [0:7];
  int log_n;
  int bad_addr;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic bit unc(input logic [1:0] s);
    return s[1];
  endfunction

  function automatic bit e_on();
    if (!unc(cs_p)) return cv_p == KEY;
    if (!unc(cs_c)) return cv_c == KEY;
    return 1'b1;
  endfunction

  function automatic logic [15:0] e_lock();
    if (!unc(ms_p)) return mv_p[15:0];
    if (!unc(ms_c)) return mv_c[15:0];
    return 16'hFFFF;
  endfunction

  function automatic bit e_flt();
    return unc(cs_p) && unc(cs_c);
  endfunction

  function automatic bit e_dbe();
    return (unc(cs_p) && unc(cs_c)) || (unc(ms_p) && unc(ms_c));
  endfunction

  // Responder: random latency, answers from the scenario contents
  initial begin
    int dly;
    dly = 0;
    rd_vld = 1'b0;
    rd_data = '0;
    rd_ecc = '0;
    forever begin
      @(negedge clk);
      if (rd_vld) begin
        rd_vld = 1'b0;
      end else if (rd_req && rst_n) begin
        if (dly > 0) begin
          dly--;
        end else begin
          case (rd_addr)
            CP: begin rd_data = cv_p; rd_ecc = cs_p; end
            CC: begin rd_data = cv_c; rd_ecc = cs_c; end
            MP: begin rd_data = mv_p; rd_ecc = ms_p; end
            MC: begin rd_data = mv_c; rd_ecc = ms_c; end
            default: begin rd_data = '0; rd_ecc = 2'b00; bad_addr++; end
          endcase
          if (log_n < 8) log_a[log_n] = rd_addr;
          log_n++;
          rd_vld = 1'b1;
          dly = $urandom_range(0, 3);
        end
      end
    end
  end

  task automatic run_case(input string name);
    logic [AW-1:0] exp_a [0:3];
    int exp_n;
    int n;
    bit pre_bad;
    bit s_on, s_dbe, s_flt;
    logic [15:0] s_lock;
    int s_n;
    rst_n = 1'b0;
    log_n = 0;
    bad_addr = 0;
    repeat (3) @(negedge clk);
    chk(!prot_on && sect_lock == 0 && !dbe_flag && !prot_fault && !load_done && !rd_req,
        "R8", {name, " reset state"}, {prot_on, dbe_flag, prot_fault, load_done}, 0);
    rst_n = 1'b1;
    pre_bad = 1'b0;
    n = 0;
    while (!load_done && n < 400) begin
      @(negedge clk);
      n++;
      if (!load_done && (prot_on || sect_lock != 0 || dbe_flag || prot_fault)) pre_bad = 1'b1;
    end
    chk(load_done, "R9", {name, " done reached"}, load_done, 1);
    chk(!pre_bad, "R8", {name, " outputs quiet before done"}, pre_bad, 0);
    exp_n = 0;
    exp_a[exp_n] = CP; exp_n++;
    if (unc(cs_p)) begin exp_a[exp_n] = CC; exp_n++; end
    exp_a[exp_n] = MP; exp_n++;
    if (unc(ms_p)) begin exp_a[exp_n] = MC; exp_n++; end
    chk(log_n == exp_n && bad_addr == 0, "R2", {name, " number of reads"}, log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++)
      chk(log_a[i] == exp_a[i], "R1", {name, " read order"}, log_a[i], exp_a[i]);
    chk(prot_on == e_on(), "R3", {name, " protection installed"}, prot_on, e_on());
    chk(sect_lock == e_lock(), "R5", {name, " sector mask"}, sect_lock, e_lock());
    chk(dbe_flag == e_dbe(), "R6", {name, " double-bit flag"}, dbe_flag, e_dbe());
    chk(prot_fault == e_flt(), "R4", {name, " protection fault"}, prot_fault, e_flt());
    s_on = prot_on; s_lock = sect_lock; s_dbe = dbe_flag; s_flt = prot_fault; s_n = log_n;
    repeat (6) @(negedge clk);
    chk(load_done && prot_on == s_on && sect_lock == s_lock && dbe_flag == s_dbe
        && prot_fault == s_flt && log_n == s_n && !rd_req,
        "R9", {name, " hold after done"}, {s_n[15:0], sect_lock}, {s_n[15:0], s_lock});
  endtask

  task automatic setc(input logic [1:0] a, input logic [31:0] av,
                      input logic [1:0] b, input logic [31:0] bv,
                      input logic [1:0] c, input logic [31:0] cvv,
                      input logic [1:0] d, input logic [31:0] dv);
    cs_p = a; cv_p = av; cs_c = b; cv_c = bv;
    ms_p = c; mv_p = cvv; ms_c = d; mv_c = dv;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R9 actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    log_n = 0;
    bad_addr = 0;
    setc(2'b00, KEY, 2'b00, 32'h0, 2'b00, 32'h1234, 2'b00, 32'h0);
    // R3 clean correct code
    run_case("clean");
    // R3 clean wrong code, the copy holds the key and must not be read (R2)
    setc(2'b00, 32'h8AFE15C2, 2'b00, KEY, 2'b00, 32'h00A5, 2'b00, 32'h5A00);
    run_case("wrong_clean");
    // R2 fallback to a clean copy
    setc(2'b10, 32'h0, 2'b00, KEY, 2'b00, 32'h0F0F, 2'b00, 32'h0);
    run_case("copy_ok");
    // R3 copy is readable but wrong
    setc(2'b10, KEY, 2'b00, 32'h12345678, 2'b00, 32'h0001, 2'b00, 32'h0);
    run_case("copy_wrong");
    // R4 both code locations unreadable
    setc(2'b10, 32'h0, 2'b10, 32'h0, 2'b00, 32'h8000, 2'b00, 32'h0);
    run_case("code_dbe");
    // R4 reserved verdict 11 treated as unusable
    setc(2'b11, KEY, 2'b11, KEY, 2'b01, 32'h0042, 2'b00, 32'h0);
    run_case("code_rsvd");
    // R2 corrected single-bit counts as usable, no copy read
    setc(2'b01, KEY, 2'b10, 32'h0, 2'b00, 32'h7777, 2'b00, 32'h0);
    run_case("code_fixed");
    // R6 mask copy fallback, corrected copy
    setc(2'b00, KEY, 2'b00, 32'h0, 2'b10, 32'h1111, 2'b01, 32'hBEEF);
    run_case("mask_copy");
    // R6 both mask locations unreadable, wrong code keeps protection off
    setc(2'b00, 32'h0, 2'b00, 32'h0, 2'b10, 32'h1111, 2'b11, 32'h2222);
    run_case("mask_dbe");
    // R5 upper half of the mask word ignored
    setc(2'b00, KEY, 2'b00, 32'h0, 2'b00, 32'hFFFF0000, 2'b00, 32'h0);
    run_case("mask_upper");
    // R7 random latency and random contents
    for (int k = 0; k < 40; k++) begin
      setc(2'($urandom_range(0, 3)), ($urandom_range(0, 1) == 1) ? KEY : $urandom(),
           2'($urandom_range(0, 3)), ($urandom_range(0, 1) == 1) ? KEY : $urandom(),
           2'($urandom_range(0, 3)), $urandom(),
           2'($urandom_range(0, 3)), $urandom());
      run_case("random");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule